// File: doc/BRIEF.md
# Time-Slot PCM Voice Port

This block carries one 8-bit voice sample per frame between a codec core and a time-slot PCM serial bus. It is clocked directly by the bus bit clock. An 8 kHz frame-sync input marks each frame. The transmit side presents a data bit together with an output-enable, which an I/O cell turns into a three-state pin. The receive side samples the serial input and returns the assembled byte with a one-cycle strobe.

Static configuration inputs choose the frame-sync timing, the slot layout, the slot used and whether transfer is enabled. The timing choice is between a rising-edge start and an early-sampled start. The layout choice is between back-to-back slots and slots with a 2-bit gap left for signalling data. The slot choice is between the first and second slot of the frame.

A control-side write can replace the transmit byte for exactly one frame. After power is applied, the transmit output is held off until the second frame start.

Top module: `pcm_slot_port`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `tx_oe`, `tx_dat` and `rx_valid` are 0.
- R2: With `dly_mode`=0, the frame starts on a rising edge at which `fs` is sampled high after being sampled low at the previous rising edge. Bit 0 of the frame is driven from the next rising edge on.
- R3: With `dly_mode`=1, `fs` is sampled on falling edges. When it is seen high after being low at the previous falling edge, bit 0 of the frame is driven from the following rising edge.
- R4: With `fmt_gap`=0, the first slot (`sel_b2`=0) holds frame bits 0..7 and the second slot (`sel_b2`=1) holds frame bits 8..15.
- R5: With `fmt_gap`=1, the first slot is unchanged and the second slot holds frame bits 10..17, so two idle bits sit between the slots.
- R6: Transmit bits change on rising edges and are sent MSB first: slot bit k carries byte bit 7-k. `tx_dat` is 0 whenever `tx_oe` is 0.
- R7: `rx_pin` is sampled on the falling edge inside each slot bit, MSB first. On the cycle after the last slot bit, `rx_byte` holds the assembled byte and `rx_valid` is 1 for that one cycle only.
- R8: `tx_oe` is 1 only during bits of the selected slot. When `xfer_en`=0, `tx_oe` stays 0 and no `rx_valid` pulse occurs.
- R9: A `sub_wr` pulse stores `sub_byte`. The byte is sent instead of `voice_tx` in the next frame to start, and only in that frame.
- R10: While `pwr_up`=0, `tx_oe` is 0. After `pwr_up` rises, the frame begun by the first frame start keeps `tx_oe` at 0. Transmission resumes with the frame of the second frame start.
- R11: The `fs` high width may be anything from one bit-clock cycle up to most of the frame. A long pulse starts only one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up | input | 1 | Codec powered-up state |
| fs | input | 1 | Frame sync |
| dly_mode | input | 1 | 0: rising-edge start, 1: early-sampled start |
| fmt_gap | input | 1 | 1: two-bit gap before the second slot |
| sel_b2 | input | 1 | 0: first slot, 1: second slot |
| xfer_en | input | 1 | Enable voice transfer |
| voice_tx | input | 8 | Voice byte from the codec core |
| sub_wr | input | 1 | Strobe storing a substitution byte |
| sub_byte | input | 8 | Substitution byte |
| rx_pin | input | 1 | Serial receive data |
| tx_dat | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit drive enable (0 means high impedance) |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe with a new `rx_byte` |

## Verification
The bit counter restarts at every frame start, so a wrong counter state shows as `tx_oe` rising one or more bit times off. It can also show as an enable window longer or shorter than eight bits, and this is visible within the frame where the error occurs. A stale substitution flag or power-up frame count shows as a wrong byte or a missing enable in the very next frame. Receive misalignment shows as a wrong `rx_byte` on the single strobe cycle, or as that strobe arriving on the wrong cycle, and both are checked every frame.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int SLOT_BITS = 8;
  localparam int GAP_BITS  = 2;

  typedef enum logic {TM_EDGE = 1'b0, TM_EARLY = 1'b1} fs_timing_t;

  // first frame bit of the chosen slot
  function automatic int slot_first(logic second, logic gap);
    int f;
    f = 0;
    if (second) f = SLOT_BITS + (gap ? GAP_BITS : 0);
    return f;
  endfunction

  // position inside the slot, negative or >= SLOT_BITS when outside
  function automatic int slot_rel(int bitpos, logic second, logic gap);
    return bitpos - slot_first(second, gap);
  endfunction

  function automatic logic slot_hit(int rel);
    return (rel >= 0) && (rel < SLOT_BITS);
  endfunction
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_port_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fs,
  input  logic             dly_mode,
  input  logic             pwr_up,
  output logic             frame_start,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             armed_nxt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int               ARM_AT  = 2;

  fs_timing_t tmode;
  logic fs_p, fs_p_d, fs_n, fs_n_d;
  logic [1:0] fcnt_q, fcnt_nxt;

  assign tmode = fs_timing_t'(dly_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_p   <= 1'b0;
      fs_p_d <= 1'b0;
    end else begin
      fs_p   <= fs;
      fs_p_d <= fs_p;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      fs_n   <= 1'b0;
      fs_n_d <= 1'b0;
    end else begin
      fs_n   <= fs;
      fs_n_d <= fs_n;
    end
  end

  always_comb begin
    if (tmode == TM_EARLY) frame_start = fs_n & ~fs_n_d;
    else                   frame_start = fs_p & ~fs_p_d;
  end

  always_comb begin
    if (frame_start)         cnt_nxt = '0;
    else if (cnt_q == CNT_MAX) cnt_nxt = CNT_MAX;
    else                     cnt_nxt = cnt_q + 1'b1;
  end

  always_comb begin
    if (!pwr_up)                                      fcnt_nxt = 2'd0;
    else if (frame_start && (int'(fcnt_q) < ARM_AT))  fcnt_nxt = fcnt_q + 2'd1;
    else                                              fcnt_nxt = fcnt_q;
  end
  assign armed_nxt = (int'(fcnt_nxt) >= ARM_AT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_MAX;
      fcnt_q <= 2'd0;
    end else begin
      cnt_q  <= cnt_nxt;
      fcnt_q <= fcnt_nxt;
    end
  end

  // R11: a held frame sync never yields two starts in a row
  single_start_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  // R2: every start places the counter at frame bit 0 on the next edge
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (cnt_q == '0));
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
  import pcm_port_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             armed_nxt,
  input  logic             pwr_up,
  input  logic             xfer_en,
  input  logic             sel_b2,
  input  logic             fmt_gap,
  input  logic [DW-1:0]    voice_tx,
  input  logic             sub_wr,
  input  logic [DW-1:0]    sub_byte,
  output logic             tx_dat,
  output logic             tx_oe
);
  logic [DW-1:0] held_q, sub_q, src, cur;
  logic          sub_pend;
  int            rel;
  logic          hit, oe_n;
  logic [2:0]    idx;

  assign src = sub_pend ? sub_q : voice_tx;
  assign cur = frame_start ? src : held_q;

  always_comb begin
    rel  = slot_rel(int'(cnt_nxt), sel_b2, fmt_gap);
    hit  = slot_hit(rel);
    idx  = ~rel[2:0];
    oe_n = hit & xfer_en & pwr_up & armed_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q   <= '0;
      sub_q    <= '0;
      sub_pend <= 1'b0;
      tx_oe    <= 1'b0;
      tx_dat   <= 1'b0;
    end else begin
      if (frame_start) held_q <= src;
      if (sub_wr) sub_q <= sub_byte;
      sub_pend <= sub_wr | (sub_pend & ~frame_start);
      tx_oe    <= oe_n;
      tx_dat   <= oe_n & cur[idx];
    end
  end

  // R10: no drive on the edge after power is seen off
  pwr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_up |=> !tx_oe);

  // R9: a start without a new write consumes the substitution
  sub_once_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !sub_wr) |=> !sub_pend);
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
  import pcm_port_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             sel_b2,
  input  logic             fmt_gap,
  input  logic             xfer_en,
  input  logic             pwr_up,
  input  logic             rx_pin,
  output logic [DW-1:0]    rx_byte,
  output logic             rx_valid
);
  logic          rx_s;
  logic [DW-1:0] sh_q;
  int            rel;
  logic          take, last;

  always_ff @(negedge clk) begin
    if (rst) rx_s <= 1'b0;
    else     rx_s <= rx_pin;
  end

  always_comb begin
    rel  = slot_rel(int'(cnt_q), sel_b2, fmt_gap);
    take = slot_hit(rel) & xfer_en & pwr_up;
    last = take & (rel == SLOT_BITS - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (take) sh_q <= {sh_q[DW-2:0], rx_s};
      if (last) rx_byte <= {sh_q[DW-2:0], rx_s};
      rx_valid <= last;
    end
  end

  // R7: the strobe lasts one cycle
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R7: the byte only changes together with the strobe
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_byte));
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int CNT_W = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_up,
  input  logic          fs,
  input  logic          dly_mode,
  input  logic          fmt_gap,
  input  logic          sel_b2,
  input  logic          xfer_en,
  input  logic [DW-1:0] voice_tx,
  input  logic          sub_wr,
  input  logic [DW-1:0] sub_byte,
  input  logic          rx_pin,
  output logic          tx_dat,
  output logic          tx_oe,
  output logic [DW-1:0] rx_byte,
  output logic          rx_valid
);
  logic             frame_start, armed_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  pcm_frame_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .fs(fs), .dly_mode(dly_mode), .pwr_up(pwr_up),
    .frame_start(frame_start), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
    .armed_nxt(armed_nxt)
  );

  pcm_tx_path #(.CNT_W(CNT_W), .DW(DW)) u_tx (
    .clk(clk), .rst(rst), .frame_start(frame_start), .cnt_nxt(cnt_nxt),
    .armed_nxt(armed_nxt), .pwr_up(pwr_up), .xfer_en(xfer_en),
    .sel_b2(sel_b2), .fmt_gap(fmt_gap), .voice_tx(voice_tx),
    .sub_wr(sub_wr), .sub_byte(sub_byte), .tx_dat(tx_dat), .tx_oe(tx_oe)
  );

  pcm_rx_path #(.CNT_W(CNT_W), .DW(DW)) u_rx (
    .clk(clk), .rst(rst), .cnt_q(cnt_q), .sel_b2(sel_b2), .fmt_gap(fmt_gap),
    .xfer_en(xfer_en), .pwr_up(pwr_up), .rx_pin(rx_pin),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  // R8: drive only follows an enabled cycle
  tx_enable_chk: assert property (@(posedge clk) disable iff (rst)
    tx_oe |-> $past(xfer_en));

  // R6: data is quiet while not driving
  tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_oe |-> !tx_dat);
endmodule

// File: tb/pcm_slot_port_tb.sv
module pcm_slot_port_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_up = 1'b1, fs = 1'b0, dly_mode = 1'b0, fmt_gap = 1'b0;
  logic sel_b2 = 1'b0, xfer_en = 1'b1, sub_wr = 1'b0, rx_pin = 1'b0;
  logic [7:0] voice_tx = 8'h00, sub_byte = 8'h00;
  logic tx_dat, tx_oe, rx_valid;
  logic [7:0] rx_byte;

  int total = 0, bad = 0;
  int fseen = 0;
  bit pend = 0;
  logic [7:0] sub_v = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_slot_port u_dut (
    .clk(clk), .rst(rst), .pwr_up(pwr_up), .fs(fs), .dly_mode(dly_mode),
    .fmt_gap(fmt_gap), .sel_b2(sel_b2), .xfer_en(xfer_en),
    .voice_tx(voice_tx), .sub_wr(sub_wr), .sub_byte(sub_byte),
    .rx_pin(rx_pin), .tx_dat(tx_dat), .tx_oe(tx_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // one frame of 24 bit times; checks every cycle
  task automatic run_frame(input logic [7:0] txv, input logic [7:0] rxv,
                           input int fs_w, input string tag);
    int base, first;
    logic [7:0] used;
    bit armed;
    base  = dly_mode ? 1 : 2;
    first = sel_b2 ? (fmt_gap ? 10 : 8) : 0;
    @(posedge clk); #2;
    voice_tx = txv;
    fs = 1'b1;
    used = pend ? sub_v : txv;
    pend = 0;
    if (pwr_up && fseen < 2) fseen++;
    armed = pwr_up && (fseen >= 2);
    for (int i = 1; i <= 24; i++) begin
      int c;
      bit in_s, exp_oe, exp_d, exp_v;
      @(posedge clk); #2;
      if (i >= fs_w) fs = 1'b0;
      c = i - base;
      in_s = (c >= first) && (c < first + 8);
      rx_pin = in_s ? rxv[7 - (c - first)] : 1'b0;
      #1;
      exp_oe = xfer_en && armed && in_s;
      exp_d  = exp_oe ? used[7 - (c - first)] : 1'b0;
      exp_v  = xfer_en && pwr_up && (i == base + first + 8);
      check(tx_oe == exp_oe, {tag, " tx_oe"}, int'(tx_oe), int'(exp_oe));
      check(tx_dat == exp_d, {tag, " tx_dat"}, int'(tx_dat), int'(exp_d));
      check(rx_valid == exp_v, {tag, " rx_valid"}, int'(rx_valid), int'(exp_v));
      if (exp_v) check(rx_byte == rxv, {tag, " rx_byte"}, int'(rx_byte), int'(rxv));
    end
  endtask

  task automatic t_reset();
    @(posedge clk); #3;
    check(tx_oe == 1'b0, "R1 oe", int'(tx_oe), 0);
    check(tx_dat == 1'b0, "R1 dat", int'(tx_dat), 0);
    check(rx_valid == 1'b0, "R1 valid", int'(rx_valid), 0);
    @(posedge clk); #2; rst = 1'b0;
    @(posedge clk); #1;
    check(tx_oe == 1'b0, "R1 oe after", int'(tx_oe), 0);
    check(rx_valid == 1'b0, "R1 valid after", int'(rx_valid), 0);
  endtask

  task automatic t_edge_timing();
    dly_mode = 0; fmt_gap = 0; sel_b2 = 0;
    run_frame(8'hA5, 8'h3C, 1, "R10 first frame off");
    run_frame(8'hC3, 8'h96, 1, "R2 R4 R6 R7 first slot");
    sel_b2 = 1;
    run_frame(8'h81, 8'h7E, 3, "R4 second slot");
  endtask

  task automatic t_early_gap();
    dly_mode = 1; fmt_gap = 1; sel_b2 = 1;
    run_frame(8'h5A, 8'hE1, 1, "R3 R5 gap slot");
    sel_b2 = 0;
    run_frame(8'h0F, 8'hF0, 2, "R3 R5 first slot");
  endtask

  task automatic t_long_fs();
    dly_mode = 1; sel_b2 = 1; fmt_gap = 0;
    run_frame(8'h69, 8'h18, 14, "R11 long early");
    dly_mode = 0;
    run_frame(8'h96, 8'h42, 20, "R11 long edge");
  endtask

  task automatic t_disable();
    xfer_en = 0;
    run_frame(8'hFF, 8'hAA, 1, "R8 disabled");
    xfer_en = 1;
    run_frame(8'h12, 8'h34, 1, "R8 re-enabled");
  endtask

  task automatic t_subst();
    sel_b2 = 0;
    @(posedge clk); #2; sub_wr = 1; sub_byte = 8'hD2;
    @(posedge clk); #2; sub_wr = 0;
    pend = 1; sub_v = 8'hD2;
    run_frame(8'h11, 8'h22, 1, "R9 substituted");
    run_frame(8'h11, 8'h23, 1, "R9 voice again");
  endtask

  task automatic t_power();
    @(posedge clk); #2; pwr_up = 0; fseen = 0;
    run_frame(8'hE7, 8'h55, 1, "R10 powered off");
    @(posedge clk); #2; pwr_up = 1;
    run_frame(8'hE7, 8'h66, 1, "R10 hold frame");
    run_frame(8'h7E, 8'h99, 1, "R10 resumed");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_edge_timing();
    t_early_gap();
    t_long_fs();
    t_disable();
    t_subst();
    t_power();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule